// File: doc/BRIEF.md
# Double-Buffered Display Reference Code Bank

This block holds the 8-bit codes for eleven buffered reference outputs: one common-voltage channel (channel 0) and ten gamma channels (channels 1 to 10). A plain register-write port (address, data, strobe) loads a first-rank register for each channel. A second rank drives the codes seen by the DAC ladders.

An external load pin decides when the second rank changes. While the pin is high, the second rank is transparent and a write reaches the DAC code at once. While the pin is low, the second rank holds its value. It takes the first-rank contents only when the pin goes from low to high, so an external pulse can time a simultaneous update of all channels. The pin is asynchronous and passes through a two-flop synchronizer before it is used.

A standby register bit forces every output enable low, which puts the buffers in high impedance. A thermal-fault input disables only the common-voltage buffer. A combinational read port returns first-rank contents and the standby register, so pending codes can be compared with applied codes.

Top module: `dac_code_bank`

## Requirements
- R1: After a synchronous active-low reset, every first-rank and second-rank code is 00h, the standby bit is clear, and every output enable is 1.
- R2: A write strobe with address 00h..0Ah stores the data byte in that channel's first rank (00h is the common-voltage channel, 01h..0Ah are the gamma channels in order). The read port returns the stored value combinationally.
- R3: A write to any address other than 00h..0Ah and 51h changes no stored code and no standby state. Reading such an address returns 00h.
- R4: While the synchronized load level is high, each channel's DAC code equals its first-rank value. A write therefore appears on the DAC code in the clock cycle right after the strobe edge.
- R5: While the synchronized load level is low, the DAC codes do not change, whatever writes occur.
- R6: A low-to-high change of the load pin updates all eleven DAC codes together to the first-rank values. The update is visible two clock edges after the pin rises.
- R7: Bit 0 of address 51h is the standby bit. While it is 1, every output enable is 0. Reading 51h returns the bit in position 0 and zeros in bits 7..1.
- R8: Writes to the channel registers are accepted and stored while standby is set.
- R9: While the thermal-fault input is 1, the common-voltage enable (bit 0) is 0 and the gamma enables are unaffected. The enable returns to 1 as soon as the input is 0 (if standby is clear).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Write strobe |
| wr_addr | input | 8 | Write address |
| wr_data | input | 8 | Write data |
| rd_addr | input | 8 | Read address |
| rd_data | output | 8 | Read data (combinational) |
| load_in | input | 1 | Asynchronous load pin |
| thermal_fault | input | 1 | Over-temperature flag, disables channel 0 |
| dac_code | output | 88 | Applied codes, channel i at bits [8i+7:8i] |
| out_en | output | 11 | Per-channel buffer enable, 1 = driving |

## Verification
The bench targets three corner cases.

1. Writes land while the load pin is low. A design that leaked them through would show a new code before the load pulse. A design that dropped them would leave a stale code after the pulse.
2. The pin rises with several channels pending. The bench expects every channel to change together after exactly two synchronizer edges. A missing or extra synchronizer stage shifts that edge, and a per-channel capture leaves some channels behind.
3. Standby and thermal fault overlap, and writes go to undefined addresses. Swapped gating would show a wrong enable pattern. A loose address decode would alias a code into an out-of-range write or make a read of an undefined address return nonzero.

// File: rtl/dac_bank_pkg.sv
// Shared sizing for the reference code bank.
// Assumes one common-voltage channel at index 0 followed by the gamma channels.
package dac_bank_pkg;
    localparam int CODE_W = 8;
    localparam int NUM_CH = 11;
    localparam int ADDR_W = 8;
    localparam logic [ADDR_W-1:0] STBY_ADDR = 8'h51;
endpackage

// File: rtl/dac_ld_sync.sv
// Synchronizes the asynchronous load pin into the clock domain.
// Assumes the pin stays at each level for more than STAGES clock cycles.
module dac_ld_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pin_in,
    output logic level_s
);
    logic [STAGES-1:0] chain;

    // shift the pin through the flop chain; reset to low (hold mode)
    always_ff @(posedge clk) begin
        if (!rst_n) chain <= '0;
        else        chain <= {chain[STAGES-2:0], pin_in};
    end

    assign level_s = chain[STAGES-1];
endmodule

// File: rtl/dac_first_rank.sv
// First-rank code registers plus the standby register, with the write decode and the read mux.
// Assumes STBY_ADDR lies outside 0..NUM_CH-1.
module dac_first_rank
    import dac_bank_pkg::*;
#(
    parameter int N  = NUM_CH,
    parameter int CW = CODE_W,
    parameter int AW = ADDR_W
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 wr_en,
    input  logic [AW-1:0]        wr_addr,
    input  logic [CW-1:0]        wr_data,
    input  logic [AW-1:0]        rd_addr,
    output logic [CW-1:0]        rd_data,
    output logic [N-1:0][CW-1:0] pend,
    output logic                 stby
);
    localparam logic [AW-1:0] LAST_CH = AW'(N - 1);

    genvar gi;
    generate
        for (gi = 0; gi < N; gi++) begin : g_ch
            // store a code when its own address is written
            always_ff @(posedge clk) begin
                if (!rst_n)                                pend[gi] <= '0;
                else if (wr_en && wr_addr == AW'(gi))      pend[gi] <= wr_data;
            end
        end
    endgenerate

    // standby bit is bit 0 of its control register
    always_ff @(posedge clk) begin
        if (!rst_n)                              stby <= 1'b0;
        else if (wr_en && wr_addr == STBY_ADDR)  stby <= wr_data[0];
    end

    // read mux: channel codes, standby register, zero elsewhere
    always_comb begin
        rd_data = '0;
        for (int i = 0; i < N; i++)
            if (rd_addr == AW'(i)) rd_data = pend[i];
        if (rd_addr == STBY_ADDR) rd_data = {{(CW-1){1'b0}}, stby};
    end

    // R3
    undecoded_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_addr > LAST_CH && wr_addr != STBY_ADDR) |=> ($stable(pend) && $stable(stby)));

    // R8
    write_lands_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_addr <= LAST_CH) |=> (rd_addr != $past(wr_addr) || rd_data == $past(wr_data)));
endmodule

// File: rtl/dac_second_rank.sv
// Second rank: transparent while the synchronized load level is high, holding while it is low.
// A rising level hands the first-rank codes to all channels in one cycle.
// Assumes level_s is already synchronous to clk.
module dac_second_rank
    import dac_bank_pkg::*;
#(
    parameter int N  = NUM_CH,
    parameter int CW = CODE_W
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 level_s,
    input  logic [N-1:0][CW-1:0] pend,
    output logic [N-1:0][CW-1:0] applied
);
    logic [N-1:0][CW-1:0] held;

    // track the first rank while transparent so a falling level freezes the last value
    always_ff @(posedge clk) begin
        if (!rst_n)       held <= '0;
        else if (level_s) held <= pend;
    end

    // flow-through path while the level is high
    assign applied = level_s ? pend : held;

    // R5
    hold_while_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!level_s && $past(!level_s)) |-> $stable(applied));
endmodule

// File: rtl/dac_code_bank.sv
// Top of the double-buffered reference code bank: write port, load timing and output enable gating.
// Assumes thermal_fault is glitch-free; it gates the common-voltage enable combinationally.
module dac_code_bank
    import dac_bank_pkg::*;
#(
    parameter int N  = NUM_CH,
    parameter int CW = CODE_W,
    parameter int AW = ADDR_W
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            wr_en,
    input  logic [AW-1:0]   wr_addr,
    input  logic [CW-1:0]   wr_data,
    input  logic [AW-1:0]   rd_addr,
    output logic [CW-1:0]   rd_data,
    input  logic            load_in,
    input  logic            thermal_fault,
    output logic [N*CW-1:0] dac_code,
    output logic [N-1:0]    out_en
);
    logic                 level_s;
    logic                 stby;
    logic [N-1:0][CW-1:0] pend;
    logic [N-1:0][CW-1:0] applied;

    dac_ld_sync #(.STAGES(2)) u_sync (
        .clk(clk), .rst_n(rst_n), .pin_in(load_in), .level_s(level_s)
    );

    dac_first_rank #(.N(N), .CW(CW), .AW(AW)) u_first (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .rd_addr(rd_addr), .rd_data(rd_data), .pend(pend), .stby(stby)
    );

    dac_second_rank #(.N(N), .CW(CW)) u_second (
        .clk(clk), .rst_n(rst_n), .level_s(level_s), .pend(pend), .applied(applied)
    );

    assign dac_code = applied;

    genvar gi;
    generate
        for (gi = 0; gi < N; gi++) begin : g_en
            if (gi == 0) begin : g_vcom
                // common-voltage buffer: off in standby or on thermal fault
                assign out_en[gi] = ~stby & ~thermal_fault;
            end else begin : g_gamma
                // gamma buffers: off only in standby
                assign out_en[gi] = ~stby;
            end
        end
    endgenerate

    // R7
    standby_all_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_addr == STBY_ADDR && rd_data[0]) |-> (out_en == '0));

    // R9
    thermal_vcom_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (thermal_fault && out_en[1]) |-> (!out_en[0] && (&out_en[N-1:1])));

    // R4
    transparent_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(load_in) && load_in && $past(load_in, 2) && rd_addr < AW'(N))
        |-> (rd_data == dac_code[CW*rd_addr[3:0] +: CW]));
endmodule

// File: tb/dac_code_bank_bench.sv
module dac_code_bank_bench;
    localparam int N  = 11;
    localparam int CW = 8;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          wr_en = 1'b0;
    logic [7:0]    wr_addr = '0;
    logic [7:0]    wr_data = '0;
    logic [7:0]    rd_addr = '0;
    logic [7:0]    rd_data;
    logic          load_in = 1'b0;
    logic          thermal_fault = 1'b0;
    logic [N*CW-1:0] dac_code;
    logic [N-1:0]  out_en;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;

    logic [7:0] m_first [N];
    logic [7:0] m_hold  [N];
    bit         m_ld;
    bit         m_stby;

    always #2.5 clk = ~clk;

    dac_code_bank u_dac_code_bank (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .rd_addr(rd_addr), .rd_data(rd_data), .load_in(load_in),
        .thermal_fault(thermal_fault), .dac_code(dac_code), .out_en(out_en)
    );

    function automatic logic [7:0] exp_code(int ch);
        return m_ld ? m_first[ch] : m_hold[ch];
    endfunction

    function automatic logic [N-1:0] exp_en();
        logic [N-1:0] e;
        e = m_stby ? '0 : '1;
        if (thermal_fault) e[0] = 1'b0;
        return e;
    endfunction

    function automatic logic [7:0] exp_rd(logic [7:0] a);
        if (a < 8'(N)) return m_first[a];
        if (a == 8'h51) return {7'b0, m_stby};
        return 8'h00;
    endfunction

    task automatic chk(string tag, logic [N*CW-1:0] act, logic [N*CW-1:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic chk_outputs(string tag);
        for (int i = 0; i < N; i++)
            chk(tag, (N*CW)'(dac_code[i*CW +: CW]), (N*CW)'(exp_code(i)));
        chk(tag, (N*CW)'(out_en), (N*CW)'(exp_en()));
    endtask

    task automatic chk_read(string tag, logic [7:0] a);
        rd_addr = a;
        #1;
        chk(tag, (N*CW)'(rd_data), (N*CW)'(exp_rd(a)));
    endtask

    task automatic do_wr(logic [7:0] a, logic [7:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
        if (a < 8'(N)) begin
            m_first[a] = d;
            if (m_ld) m_hold[a] = d;
        end else if (a == 8'h51) begin
            m_stby = d[0];
        end
    endtask

    task automatic set_ld(bit v);
        @(negedge clk);
        load_in = v;
        repeat (3) @(negedge clk);
        m_ld = v;
        if (v) for (int i = 0; i < N; i++) m_hold[i] = m_first[i];
    endtask

    initial begin
        #(5.0 * 150000);
        if (!done) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog expired");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        logic [7:0] pre [N];
        void'($urandom(32'h1357));
        for (int i = 0; i < N; i++) begin m_first[i] = '0; m_hold[i] = '0; end
        m_ld = 1'b0; m_stby = 1'b0;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        chk_outputs("R1 reset outputs");
        for (int a = 0; a < N; a++) chk_read("R1 reset read", 8'(a));
        chk_read("R1 reset standby", 8'h51);

        // R2 store and read back; R5 hold while load low
        do_wr(8'h03, 8'hAA);
        do_wr(8'h00, 8'h5C);
        do_wr(8'h0A, 8'hFF);
        chk_read("R2 readback ch3", 8'h03);
        chk_read("R2 readback ch10", 8'h0A);
        chk_outputs("R5 pending not applied");

        // R6 edge timing: nothing after one edge, all channels after two
        @(negedge clk);
        load_in = 1'b1;
        @(negedge clk);
        for (int i = 0; i < N; i++) pre[i] = m_hold[i];
        for (int i = 0; i < N; i++)
            chk("R6 not yet after one edge", (N*CW)'(dac_code[i*CW +: CW]), (N*CW)'(pre[i]));
        @(negedge clk);
        m_ld = 1'b1;
        for (int i = 0; i < N; i++) m_hold[i] = m_first[i];
        chk_outputs("R6 simultaneous update");

        // R4 transparent writes appear next cycle
        do_wr(8'h05, 8'h3F);
        chk_outputs("R4 flow-through");
        set_ld(1'b0);
        do_wr(8'h05, 8'h01);
        do_wr(8'h00, 8'h02);
        chk_outputs("R5 hold after fall");

        // R3 undefined addresses
        do_wr(8'h0B, 8'h77);
        do_wr(8'hFF, 8'h66);
        do_wr(8'h50, 8'h01);
        chk_read("R3 read 0B", 8'h0B);
        chk_read("R3 read FF", 8'hFF);
        for (int a = 0; a < N; a++) chk_read("R3 bank untouched", 8'(a));
        chk_read("R3 standby untouched", 8'h51);
        chk_outputs("R3 enables untouched");

        // R7 standby, R8 writes while standing by
        do_wr(8'h51, 8'hFF);
        chk_read("R7 standby reads 01", 8'h51);
        chk_outputs("R7 all enables low");
        do_wr(8'h09, 8'hC3);
        chk_read("R8 write in standby", 8'h09);
        thermal_fault = 1'b1; #1;
        chk_outputs("R7 standby with fault");
        thermal_fault = 1'b0;
        do_wr(8'h51, 8'h00);
        chk_outputs("R7 standby cleared");

        // R9 thermal fault on channel 0 only
        @(negedge clk); thermal_fault = 1'b1; #1;
        chk_outputs("R9 fault gates ch0");
        @(negedge clk); thermal_fault = 1'b0; #1;
        chk_outputs("R9 fault released");

        // random mix
        for (int it = 0; it < 400; it++) begin
            int op;
            logic [7:0] a;
            op = int'($urandom_range(0, 9));
            if (op < 6) begin
                case ($urandom_range(0, 3))
                    0: a = 8'h51;
                    1: a = 8'($urandom_range(0, 255));
                    default: a = 8'($urandom_range(0, N - 1));
                endcase
                do_wr(a, 8'($urandom_range(0, 255)));
                chk_read("R2 R3 R7 random read", a);
                chk_outputs("R4 R5 R8 random outputs");
            end else if (op < 8) begin
                set_ld(~m_ld);
                chk_outputs("R6 random load change");
            end else begin
                @(negedge clk);
                thermal_fault = $urandom_range(0, 1) == 1;
                #1;
                chk_outputs("R9 random thermal");
            end
        end

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule